// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block runs a complete flash program or flash erase procedure on a debug target. It sits above a memory access sequencer and delegates every serial scan to it. For each procedure it issues an ordered list of access steps: halt the CPU, three keyed writes to the flash controller's configuration registers, a trigger write, and a switch of the access path back to read mode. It then produces a counted burst of test-clock pulses that time the flash operation. A final keyed write disables flash writes, and `done` is raised.

A command is a one-cycle `cmd_valid` strobe that carries the operation type, an address, a data word, an erase mode word and a pulse count. Programming always uses a fixed number of pulses. An erase uses the pulse count the caller supplies. For a mass erase the caller passes mode 0xA506, address 0xFFFE and 0x3000 pulses. Verify and retry policy are left to the caller.

States: `ST_IDLE`, `ST_HALT`, `ST_CFG_CMD`, `ST_CFG_CLK`, `ST_CFG_LOCK`, `ST_TRIGGER`, `ST_READMODE`, `ST_BURST`, `ST_DISABLE`, `ST_FINISH`. The transitions are as follows:
- `ST_IDLE` goes to `ST_HALT` on `cmd_valid`.
- Each step state from `ST_HALT` through `ST_READMODE`, and also `ST_DISABLE`, moves to its successor when the access sequencer acknowledges that step.
- `ST_READMODE` goes to `ST_BURST`, which starts the pulse counter.
- `ST_BURST` goes to `ST_DISABLE` when the burst ends.
- `ST_DISABLE` goes to `ST_FINISH`.
- `ST_FINISH` goes to `ST_IDLE` after one cycle.

Top module: `flash_seq`

## Requirements
- R1: After reset `busy`, `done`, `acc_req`, `tclk` and `tclk_drive` are all 0.
- R2: A program command (`cmd_erase`=0) issues seven steps in this order. Access op codes are HALT=0, WRITE=1, READMODE=2, and address and data are 0 for non-write ops.
  1. HALT.
  2. WRITE 0xA540 to 0x0128.
  3. WRITE 0xA540 to 0x012A.
  4. WRITE 0xA500 to 0x012C.
  5. WRITE `cmd_data` to `cmd_addr`.
  6. READMODE.
  7. WRITE 0xA500 to 0x0128.
- R3: An erase command (`cmd_erase`=1) issues the same sequence, with two differences: step 2 writes `cmd_mode` to 0x0128, and step 5 writes 0x55AA to `cmd_addr`.
- R4: Between the READMODE step and the final write, `tclk` shows exactly PROG_PULSES (default 35) rising edges for a program command, and exactly `cmd_count` rising edges for an erase command.
- R5: During a burst every high phase and every low phase of `tclk` lasts exactly DIV_CYC clock cycles. `tclk` is 0 whenever `tclk_drive` is 0.
- R6: An erase with `cmd_count`=0 produces no `tclk` pulse and still completes the full step sequence.
- R7: `acc_req` is a one-cycle strobe. No new step is requested until the current step's `acc_done` arrives. Except after READMODE, the next request comes in the cycle right after `acc_done`.
- R8: `busy` is 1 from the cycle after acceptance until `done`. `done` is a single-cycle pulse in the cycle after the final step's `acc_done`, and `busy` is 0 in the cycle after `done`.
- R9: `cmd_valid` while `busy` is 1 is ignored. The running sequence and its operands are unchanged, and no second procedure follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, accepted only when idle |
| cmd_erase | input | 1 | 0 = program word, 1 = erase |
| cmd_addr | input | AW | Target or erase address |
| cmd_data | input | DW | Word to program |
| cmd_mode | input | DW | Erase mode word |
| cmd_count | input | CW | Erase pulse count |
| busy | output | 1 | Procedure in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_req | output | 1 | Step request strobe to the access sequencer |
| acc_op | output | 2 | Step op code: 0 halt, 1 write, 2 read mode |
| acc_addr | output | AW | Write address |
| acc_wdata | output | DW | Write data |
| acc_done | input | 1 | Step completed by the access sequencer |
| tclk | output | 1 | Flash timing clock during a burst |
| tclk_drive | output | 1 | High while this block owns the test clock |

## Verification
A step request appears in the cycle after the previous `acc_done`. `done` appears one cycle after the final `acc_done`. A burst starts in the cycle after the READMODE acknowledge, and each pulse occupies 2×DIV_CYC cycles. The bench's access-sequencer model samples on falling edges and stamps each `acc_done` with a rising-edge cycle count. It compares each following request, and `done`, against that stamp plus one. It measures every `tclk` high and low run in whole cycles and counts rising edges per procedure. It compares the logged steps only after `done` has been seen.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        AOP_HALT     = 2'd0,
        AOP_WRITE    = 2'd1,
        AOP_READMODE = 2'd2
    } acc_op_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HALT,
        ST_CFG_CMD,
        ST_CFG_CLK,
        ST_CFG_LOCK,
        ST_TRIGGER,
        ST_READMODE,
        ST_BURST,
        ST_DISABLE,
        ST_FINISH
    } seq_state_t;

    localparam logic [15:0] CFG_CMD_ADDR  = 16'h0128;
    localparam logic [15:0] CFG_CLK_ADDR  = 16'h012A;
    localparam logic [15:0] CFG_LOCK_ADDR = 16'h012C;
    localparam logic [15:0] KEY_WRITE_EN  = 16'hA540;
    localparam logic [15:0] KEY_CLK_SEL   = 16'hA540;
    localparam logic [15:0] KEY_UNLOCK    = 16'hA500;
    localparam logic [15:0] KEY_IDLE      = 16'hA500;
    localparam logic [15:0] ERASE_DUMMY   = 16'h55AA;

endpackage

// File: rtl/flash_tick_div.sv
module flash_tick_div #(
    parameter int DIV_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic en,
    output logic tick
);
    localparam int W = (DIV_CYC > 1) ? $clog2(DIV_CYC) : 1;
    localparam logic [W-1:0] LAST = W'(DIV_CYC - 1);

    logic [W-1:0] cnt;

    assign tick = en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clear || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/flash_tclk_burst.sv
module flash_tclk_burst #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] count,
    input  logic          tick,
    output logic          running,
    output logic          tclk,
    output logic          fin
);
    logic [CW-1:0] remain;
    logic          phase;

    assign tclk = phase;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain  <= '0;
            phase   <= 1'b0;
            running <= 1'b0;
            fin     <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (start) begin
                remain  <= count;
                phase   <= 1'b0;
                running <= (count != '0);
                fin     <= (count == '0);
            end else if (running && tick) begin
                if (!phase) begin
                    phase <= 1'b1;
                end else begin
                    phase  <= 1'b0;
                    remain <= remain - 1'b1;
                    if (remain == CW'(1)) begin
                        running <= 1'b0;
                        fin     <= 1'b1;
                    end
                end
            end
        end
    end

    AST_PHASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !start) |=> $stable(tclk)); // R5

    AST_REMAIN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (remain != '0)); // R4
endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 16,
    parameter int CW          = 16,
    parameter int DIV_CYC     = 2,
    parameter int PROG_PULSES = 35
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_erase,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic [DW-1:0] cmd_mode,
    input  logic [CW-1:0] cmd_count,
    output logic          busy,
    output logic          done,
    output logic          acc_req,
    output logic [1:0]    acc_op,
    output logic [AW-1:0] acc_addr,
    output logic [DW-1:0] acc_wdata,
    input  logic          acc_done,
    output logic          tclk,
    output logic          tclk_drive
);
    localparam logic [CW-1:0] PROG_CNT = CW'(PROG_PULSES);

    seq_state_t    state, nxt;
    logic          issued;
    logic          erase_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic [DW-1:0] mode_q;
    logic [CW-1:0] count_q;
    logic          step_state, step_ack;
    logic          burst_start, burst_fin, tick;
    acc_op_t       op_c;

    assign step_state = (state == ST_HALT) || (state == ST_CFG_CMD) ||
                        (state == ST_CFG_CLK) || (state == ST_CFG_LOCK) ||
                        (state == ST_TRIGGER) || (state == ST_READMODE) ||
                        (state == ST_DISABLE);
    assign step_ack    = step_state && issued && acc_done;
    assign burst_start = (state == ST_READMODE) && step_ack;

    flash_tick_div #(.DIV_CYC(DIV_CYC)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (burst_start),
        .en    (tclk_drive),
        .tick  (tick)
    );

    flash_tclk_burst #(.CW(CW)) u_burst (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (burst_start),
        .count   (erase_q ? count_q : PROG_CNT),
        .tick    (tick),
        .running (tclk_drive),
        .tclk    (tclk),
        .fin     (burst_fin)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Handshake flag and command operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issued  <= 1'b0;
            erase_q <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            mode_q  <= '0;
            count_q <= '0;
        end else begin
            if (acc_req)       issued <= 1'b1;
            else if (acc_done) issued <= 1'b0;
            if (state == ST_IDLE && cmd_valid) begin
                erase_q <= cmd_erase;
                addr_q  <= cmd_addr;
                data_q  <= cmd_data;
                mode_q  <= cmd_mode;
                count_q <= cmd_count;
            end
        end
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (cmd_valid) nxt = ST_HALT;
            ST_HALT:     if (step_ack)  nxt = ST_CFG_CMD;
            ST_CFG_CMD:  if (step_ack)  nxt = ST_CFG_CLK;
            ST_CFG_CLK:  if (step_ack)  nxt = ST_CFG_LOCK;
            ST_CFG_LOCK: if (step_ack)  nxt = ST_TRIGGER;
            ST_TRIGGER:  if (step_ack)  nxt = ST_READMODE;
            ST_READMODE: if (step_ack)  nxt = ST_BURST;
            ST_BURST:    if (burst_fin) nxt = ST_DISABLE;
            ST_DISABLE:  if (step_ack)  nxt = ST_FINISH;
            ST_FINISH:                  nxt = ST_IDLE;
            default:                    nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        op_c      = AOP_WRITE;
        acc_addr  = '0;
        acc_wdata = '0;
        unique case (state)
            ST_HALT:     op_c = AOP_HALT;
            ST_CFG_CMD:  begin
                acc_addr  = AW'(CFG_CMD_ADDR);
                acc_wdata = erase_q ? mode_q : DW'(KEY_WRITE_EN);
            end
            ST_CFG_CLK:  begin
                acc_addr  = AW'(CFG_CLK_ADDR);
                acc_wdata = DW'(KEY_CLK_SEL);
            end
            ST_CFG_LOCK: begin
                acc_addr  = AW'(CFG_LOCK_ADDR);
                acc_wdata = DW'(KEY_UNLOCK);
            end
            ST_TRIGGER:  begin
                acc_addr  = addr_q;
                acc_wdata = erase_q ? DW'(ERASE_DUMMY) : data_q;
            end
            ST_READMODE: op_c = AOP_READMODE;
            ST_DISABLE:  begin
                acc_addr  = AW'(CFG_CMD_ADDR);
                acc_wdata = DW'(KEY_IDLE);
            end
            default:     op_c = AOP_WRITE;
        endcase
        acc_op  = op_c;
        acc_req = step_state && !issued;
        busy    = (state != ST_IDLE);
        done    = (state == ST_FINISH);
    end

    AST_REQ_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req |=> !acc_req); // R7

    AST_TCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        !tclk_drive |-> !tclk); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R8

    AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(addr_q) && $stable(data_q) && $stable(erase_q))); // R9
endmodule

// File: tb/flash_seq_bench.sv
module flash_seq_bench;
    localparam int DIV_CYC = 2;
    localparam int LAT     = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_erase = 1'b0;
    logic [15:0] cmd_addr = '0, cmd_data = '0, cmd_mode = '0, cmd_count = '0;
    logic        busy, done, acc_req, acc_done = 1'b0, tclk, tclk_drive;
    logic [1:0]  acc_op;
    logic [15:0] acc_addr, acc_wdata;

    int nchecks = 0, nfails = 0;
    int cyc = 0;
    int last_done_cyc = -10;
    int lat_cnt = 0;
    int nlog = 0;
    logic [1:0]  log_op [16];
    logic [15:0] log_addr [16];
    logic [15:0] log_data [16];
    int npulse = 0;
    int hi_run = 0, lo_run = 0;
    logic prev_tclk = 1'b0;

    flash_seq u_flash_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_erase(cmd_erase),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_mode(cmd_mode),
        .cmd_count(cmd_count), .busy(busy), .done(done), .acc_req(acc_req),
        .acc_op(acc_op), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_done(acc_done), .tclk(tclk), .tclk_drive(tclk_drive)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchecks++;
        if (!ok) begin
            nfails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Access sequencer model and tclk monitor, on falling edges
    always @(negedge clk) begin
        if (acc_done) acc_done = 1'b0;
        if (lat_cnt > 0) begin
            lat_cnt--;
            if (lat_cnt == 0) begin
                acc_done = 1'b1;
                last_done_cyc = cyc;
            end
        end
        if (acc_req) begin
            check(lat_cnt == 0, "R7 request while step pending", lat_cnt, 0);
            if (nlog > 0 && log_op[nlog-1] != 2'd2)
                check(cyc == last_done_cyc + 1, "R7 request gap", cyc - last_done_cyc, 1);
            if (nlog < 16) begin
                log_op[nlog] = acc_op; log_addr[nlog] = acc_addr; log_data[nlog] = acc_wdata;
            end
            nlog++;
            lat_cnt = LAT;
        end
        if (!tclk_drive && tclk) check(0, "R5 tclk high undriven", 1, 0);
        if (tclk_drive) begin
            if (tclk && !prev_tclk) begin
                npulse++;
                check(lo_run == DIV_CYC, "R5 low phase", lo_run, DIV_CYC);
                lo_run = 0;
            end
            if (!tclk && prev_tclk) begin
                check(hi_run == DIV_CYC, "R5 high phase", hi_run, DIV_CYC);
                hi_run = 0;
            end
            if (tclk) hi_run++; else lo_run++;
        end else begin
            if (prev_tclk) begin
                check(hi_run == DIV_CYC, "R5 high phase", hi_run, DIV_CYC);
            end
            hi_run = 0; lo_run = 0;
        end
        prev_tclk = tclk;
    end

    task automatic issue(input bit er, input logic [15:0] a, d, m, c);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_erase = er; cmd_addr = a; cmd_data = d; cmd_mode = m; cmd_count = c;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(busy == 1'b1, "R8 busy after accept", busy, 1);
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 60000) begin @(negedge clk); n++; end
        check(done == 1'b1, req, done, 1);
        check(cyc == last_done_cyc + 1, "R8 done timing", cyc - last_done_cyc, 1);
        @(negedge clk);
        check(!done && !busy, "R8 done single, busy low", {done, busy}, 0);
    endtask

    task automatic check_seq(input string req, input bit er, input logic [15:0] a, d, m);
        logic [1:0]  eo [7];
        logic [15:0] ea [7];
        logic [15:0] ed [7];
        eo = '{2'd0, 2'd1, 2'd1, 2'd1, 2'd1, 2'd2, 2'd1};
        ea = '{16'h0, 16'h0128, 16'h012A, 16'h012C, a, 16'h0, 16'h0128};
        ed = '{16'h0, er ? m : 16'hA540, 16'hA540, 16'hA500, er ? 16'h55AA : d, 16'h0, 16'hA500};
        check(nlog == 7, req, nlog, 7);
        for (int i = 0; i < 7; i++) begin
            if (i < nlog)
                check(log_op[i] == eo[i] && log_addr[i] == ea[i] && log_data[i] == ed[i], req,
                      {log_op[i], log_addr[i], log_data[i]}, {eo[i], ea[i], ed[i]});
        end
    endtask

    task automatic clear_log();
        nlog = 0; npulse = 0;
    endtask

    task automatic t_reset();
        check({busy, done, acc_req, tclk, tclk_drive} == 5'b0, "R1 reset outputs",
              {busy, done, acc_req, tclk, tclk_drive}, 0);
    endtask

    task automatic t_program();
        clear_log();
        issue(1'b0, 16'hE000, 16'h1234, 16'hA502, 16'd7);
        wait_done("R8 program done");
        check_seq("R2 program steps", 1'b0, 16'hE000, 16'h1234, 16'h0);
        check(npulse == 35, "R4 program pulses", npulse, 35);
    endtask

    task automatic t_seg_erase();
        clear_log();
        issue(1'b1, 16'hF000, 16'hBEEF, 16'hA502, 16'd5);
        wait_done("R8 erase done");
        check_seq("R3 segment erase steps", 1'b1, 16'hF000, 16'h0, 16'hA502);
        check(npulse == 5, "R4 erase pulses", npulse, 5);
    endtask

    task automatic t_zero();
        clear_log();
        issue(1'b1, 16'hC000, 16'h0, 16'hA504, 16'd0);
        wait_done("R6 zero-count done");
        check_seq("R6 zero-count steps", 1'b1, 16'hC000, 16'h0, 16'hA504);
        check(npulse == 0, "R6 no pulses", npulse, 0);
    endtask

    task automatic t_busy_ignore();
        clear_log();
        issue(1'b0, 16'hE100, 16'h5A5A, 16'h0, 16'h0);
        repeat (3) @(negedge clk);
        cmd_valid = 1'b1; cmd_erase = 1'b1; cmd_addr = 16'h1111; cmd_mode = 16'hA50E; cmd_count = 16'd3;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (30) @(negedge clk);
        cmd_valid = 1'b1; cmd_addr = 16'h2222;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_done("R9 done");
        check_seq("R9 steps unchanged", 1'b0, 16'hE100, 16'h5A5A, 16'h0);
        check(npulse == 35, "R9 pulses unchanged", npulse, 35);
        repeat (20) @(negedge clk);
        check(busy == 1'b0 && nlog == 7, "R9 no second procedure", nlog, 7);
    endtask

    task automatic t_mass_erase();
        clear_log();
        issue(1'b1, 16'hFFFE, 16'h0, 16'hA506, 16'h3000);
        wait_done("R8 mass erase done");
        check_seq("R3 mass erase steps", 1'b1, 16'hFFFE, 16'h0, 16'hA506);
        check(npulse == 16'h3000, "R4 mass erase pulses", npulse, 16'h3000);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_seg_erase();
        t_zero();
        t_busy_ignore();
        t_mass_erase();
        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfails);
        $finish;
    end
endmodule